// File: doc/BRIEF.md
# Latched-Address 3-to-8 Decoder

The block turns a three-bit select address into eight active-low lines. Exactly one line, the one whose index equals the address, is driven low. A latch-enable input picks the mode. While it is low, the live select inputs are decoded with no register in the path. While it is high, a held copy of the address is decoded, and the select inputs may change freely without disturbing the outputs. This suits strobed bus systems where an address is valid only briefly.

The held copy sits in a register clocked by the system clock. The register reloads on every edge at which latch-enable is low, so raising latch-enable freezes the last address sampled in flow mode. Two output enables of opposite polarity gate all eight lines at once. Tying the fourth address bit to the active-low enable of one instance and to the active-high enable of a second instance gives a 4-to-16 decoder.

Top module: `latched_decoder`

## Requirements
- R1: With latch_en_i low and the block enabled, y_no[sel_i] is low and the other seven outputs are high in the same cycle, with no clock edge needed. sel_i[2] is the most significant bit and sel_i[0] the least.
- R2: At each rising clk_i edge where latch_en_i is low, the register loads sel_i. With latch_en_i high, decoding uses the value loaded at the last such edge.
- R3: While latch_en_i stays high, changes on sel_i have no effect on y_no.
- R4: If en_i is low or en_ni is high, all eight outputs are high, whatever sel_i, latch_en_i or the held address.
- R5: Toggling en_i or en_ni does not change the held address. When the block is re-enabled in hold mode, the same output goes low again.
- R6: While rst_ni is low, the held address is cleared to 0. Reset does not bypass the enable gating.
- R7: No more than one output is low at any time.
- R8: In a cascade of two instances, address bit 3 drives en_ni of the low instance and en_i of the high instance. The sixteen outputs {high, low} then decode a 4-bit address with one line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears held address |
| latch_en_i | input | 1 | Low: decode sel_i directly; high: decode held address |
| en_i | input | 1 | Active-high output enable |
| en_ni | input | 1 | Active-low output enable |
| sel_i | input | 3 | Select address |
| y_no | output | 8 | Active-low decoded outputs |

## Verification
In flow mode and for every change of the enables, the results are due in the same cycle as the stimulus. The bench therefore drives inputs at the falling edge and samples one nanosecond later, before the next rising edge. A captured address needs exactly one rising edge with latch_en_i low. Hold-mode checks are made only after that edge has passed and latch_en_i has been raised at the following falling edge. Select changes in hold mode are then checked at each later falling edge, with no edge skipped.

// File: rtl/latdec_pkg.sv
package latdec_pkg;
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_HOLD = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/latdec_addr_latch.sv
module latdec_addr_latch
  import latdec_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] addr_o
);
  addr_mode_e       mode;
  logic [SEL_W-1:0] held_q;

  assign mode = latch_en_i ? MODE_HOLD : MODE_FLOW;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                held_q <= '0;
    else if (mode == MODE_FLOW) held_q <= sel_i;
  end

  // flow mode bypasses the register: no added latency
  always_comb begin
    unique case (mode)
      MODE_FLOW: addr_o = sel_i;
      MODE_HOLD: addr_o = held_q;
      default:   addr_o = held_q;
    endcase
  end
endmodule

// File: rtl/latdec_onehot.sv
module latdec_onehot #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] addr_i,
  output logic [OUT_N-1:0] hot_o
);
  for (genvar i = 0; i < OUT_N; i++) begin : g_line
    assign hot_o[i] = (addr_i == SEL_W'(i));
  end
endmodule

// File: rtl/latdec_out_gate.sv
module latdec_out_gate #(
  parameter int unsigned OUT_N = 8
) (
  input  logic [OUT_N-1:0] hot_i,
  input  logic             en_i,
  input  logic             en_ni,
  output logic [OUT_N-1:0] y_no
);
  logic on;
  assign on   = en_i & ~en_ni;
  assign y_no = on ? ~hot_i : '1;
endmodule

// File: rtl/latched_decoder.sv
module latched_decoder #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             latch_en_i,
  input  logic             en_i,
  input  logic             en_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic [OUT_N-1:0] y_no
);
  logic [SEL_W-1:0] addr;
  logic [OUT_N-1:0] hot;

  latdec_addr_latch #(.SEL_W(SEL_W)) i_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .latch_en_i (latch_en_i),
    .sel_i      (sel_i),
    .addr_o     (addr)
  );

  latdec_onehot #(.SEL_W(SEL_W)) i_onehot (
    .addr_i (addr),
    .hot_o  (hot)
  );

  latdec_out_gate #(.OUT_N(OUT_N)) i_gate (
    .hot_i (hot),
    .en_i  (en_i),
    .en_ni (en_ni),
    .y_no  (y_no)
  );
endmodule

// File: rtl/latched_decoder_chk.sv
module latched_decoder_chk #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned OUT_N = 1 << SEL_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             latch_en_i,
  input logic             en_i,
  input logic             en_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic [OUT_N-1:0] y_no
);
  logic on;
  assign on = en_i & ~en_ni;

  // R7
  one_low_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~y_no) <= 1);

  // R4
  gated_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on |-> (y_no == '1));

  // R1
  flow_decode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && !latch_en_i) |-> (y_no[sel_i] == 1'b0));

  // R2
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && latch_en_i && $past(!latch_en_i) && $past(rst_ni))
      |-> (y_no[$past(sel_i)] == 1'b0));

  // R3
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on && latch_en_i && $past(latch_en_i) && $past(on)) |-> $stable(y_no));
endmodule

bind latched_decoder latched_decoder_chk #(.SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_latched_decoder.sv
module test_latched_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       le = 1'b0, en = 1'b1, en_n = 1'b0;
  logic [2:0] sel = '0;
  logic [7:0] y;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // cascade
  logic [3:0]  a16 = '0;
  logic [7:0]  y_lo, y_hi;

  always #2 clk = ~clk;

  latched_decoder i_latched_decoder (
    .clk_i(clk), .rst_ni(rst_n), .latch_en_i(le), .en_i(en), .en_ni(en_n),
    .sel_i(sel), .y_no(y));

  latched_decoder i_latched_decoder_lo (
    .clk_i(clk), .rst_ni(rst_n), .latch_en_i(1'b0), .en_i(1'b1), .en_ni(a16[3]),
    .sel_i(a16[2:0]), .y_no(y_lo));

  latched_decoder i_latched_decoder_hi (
    .clk_i(clk), .rst_ni(rst_n), .latch_en_i(1'b0), .en_i(a16[3]), .en_ni(1'b0),
    .sel_i(a16[2:0]), .y_no(y_hi));

  // {en, en_n, sel, expected y}, all in flow mode
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 8'hFE}, {1'b1, 1'b0, 3'd1, 8'hFD},
    {1'b1, 1'b0, 3'd2, 8'hFB}, {1'b1, 1'b0, 3'd3, 8'hF7},
    {1'b1, 1'b0, 3'd4, 8'hEF}, {1'b1, 1'b0, 3'd5, 8'hDF},
    {1'b1, 1'b0, 3'd6, 8'hBF}, {1'b1, 1'b0, 3'd7, 8'h7F},
    {1'b0, 1'b0, 3'd2, 8'hFF}, {1'b1, 1'b1, 3'd2, 8'hFF},
    {1'b0, 1'b1, 3'd2, 8'hFF}, {1'b1, 1'b0, 3'd2, 8'hFB},
    {1'b0, 1'b0, 3'd7, 8'hFF}, {1'b1, 1'b0, 3'd7, 8'h7F}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic e, input logic en_b, input logic [2:0] s);
    @(negedge clk);
    le = l; en = e; en_n = en_b; sel = s;
    #1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R6: reset clears held address, hold mode shows line 0
    le = 1'b1; en = 1'b1; en_n = 1'b0; sel = 3'd5;
    repeat (2) @(posedge clk);
    #1;
    chk("R6", {8'h00, y}, {8'h00, 8'hFE});
    en = 1'b0; #1;
    chk("R6", {8'h00, y}, {8'h00, 8'hFF});
    en = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b0, 3'd6);
    chk("R6", {8'h00, y}, {8'h00, 8'hFE});

    // R1 and R4 table walk
    for (int i = 0; i < NV; i++) begin
      drive(1'b0, VEC[i][12], VEC[i][11], VEC[i][10:8]);
      chk(VEC[i][7:0] == 8'hFF ? "R4" : "R1", {8'h00, y}, {8'h00, VEC[i][7:0]});
      chk("R7", 16'($countones(~y) <= 1), 16'd1);
    end

    // R2: capture 3, then raise latch enable with new select
    drive(1'b0, 1'b1, 1'b0, 3'd3);
    drive(1'b1, 1'b1, 1'b0, 3'd6);
    chk("R2", {8'h00, y}, {8'h00, 8'hF7});
    // R3: select changes ignored while held
    for (int s = 0; s < 8; s++) begin
      drive(1'b1, 1'b1, 1'b0, 3'(s));
      chk("R3", {8'h00, y}, {8'h00, 8'hF7});
    end
    // R4/R5: disable while held, change select, re-enable
    drive(1'b1, 1'b0, 1'b0, 3'd1);
    chk("R4", {8'h00, y}, {8'h00, 8'hFF});
    drive(1'b1, 1'b1, 1'b1, 3'd4);
    chk("R4", {8'h00, y}, {8'h00, 8'hFF});
    drive(1'b1, 1'b1, 1'b0, 3'd0);
    chk("R5", {8'h00, y}, {8'h00, 8'hF7});
    // R2: back to flow, capture 7, hold
    drive(1'b0, 1'b1, 1'b0, 3'd7);
    chk("R1", {8'h00, y}, {8'h00, 8'h7F});
    drive(1'b1, 1'b1, 1'b0, 3'd2);
    chk("R2", {8'h00, y}, {8'h00, 8'h7F});

    // R8: 4-to-16 cascade
    for (int a = 0; a < 16; a++) begin
      @(negedge clk); a16 = 4'(a); #1;
      chk("R8", {y_hi, y_lo}, ~(16'd1 << a));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule